// File: doc/BRIEF.md
# Free-Running Timer with Output Compare

The block is a 16-bit up-counter with two output-compare channels, reached through a simple word-addressed register bus. The counter advances on a count step. A two-bit field picks where the steps come from: one of three fixed divisions of the system clock, or the rising edges of an external count-enable line. That line is synchronised to the system clock before it is used.

Each channel holds a compare word. When a count step moves the counter onto a value equal to a compare word, the channel's status flag is set. If that channel's output is enabled, its pin is driven to the level programmed for it. Channel A can also restart the counter from zero. A wrap of the counter from its top value sets an overflow flag. Software clears a flag in two steps: it reads the flag while the flag is set, then writes 0 to it.

Register map (word address on `bus_addr`): 0 counter, 1 compare A, 2 compare B, 3 control, 4 status.

Top module: `frt_timer`

## Requirements
- R1: The counter at address 0 is 16 bits wide, resets to 0x0000 and can be written and read as a full word. Each count step adds one, except where R11 applies.
- R2: Control bits [1:0] select the count source. 00 gives one step every 2 system clocks, 01 one step every 8 and 10 one step every 32.
- R3: With control bits [1:0] = 11, each rising edge of `ext_cnt_en` gives exactly one count step, after a two-stage synchroniser. While the line is steady the counter holds.
- R4: A count step taken from 0xFFFF sets status bit 0 (overflow) to 1.
- R5: Both compare words (address 1 for A, address 2 for B) reset to 0xFFFF. A count step that lands the counter on a value equal to a compare word sets that channel's flag: status bit 1 for A, status bit 2 for B. A CPU write that makes the counter equal to a compare word sets no flag.
- R6: On a match, a channel with its output enabled drives its pin to its programmed level. Control bit 3 enables output A and bit 5 sets its level. Control bit 4 enables output B and bit 6 sets its level. A channel with its output disabled leaves its pin unchanged.
- R7: `cmp_out_a` and `cmp_out_b` are 0 from reset until their first match with the output enabled.
- R8: A write to the counter or to either compare word without both byte enables set (`bus_be` other than 11) has no effect.
- R9: A write of 0 to a status bit clears that bit only if a status read saw the bit at 1 since the last status write. A write of 0 without such a read leaves the bit set. A hardware set in the same cycle as a clear wins. The status and control registers are written through byte enable bit 0.
- R10: A full-word CPU write to the counter takes priority over a count step or a clear in the same cycle.
- R11: With control bit 2 set, a count step taken while the counter equals compare word A loads 0x0000 instead of incrementing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_addr | input | 3 | Register word address |
| bus_be | input | 2 | Byte enables for the write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register, valid in the same cycle |
| ext_cnt_en | input | 1 | External count-enable line, asynchronous |
| cmp_out_a | output | 1 | Compare output pin of channel A |
| cmp_out_b | output | 1 | Compare output pin of channel B |

## Verification
Read data is combinational, so each expected value is compared at the falling edge inside the read cycle. A register write is visible to a read in the next cycle. A count step updates the counter, the flags and the pins on the same clock edge. An external edge reaches the counter three clocks after the line rises, so every pulse is followed by idle cycles before any check. Prescaler ratios are measured as the difference between two reads spaced exactly 64, 256 or 1024 cycles apart, which holds whatever the prescaler phase is. The write-priority check puts a counter write and a read in back-to-back cycles at two adjacent phases, so one of the writes is sure to fall on a count step.

// File: rtl/frt_pkg.sv
package frt_pkg;

    localparam int CNT_W = 16;
    localparam int PS_W  = 5;

    typedef logic [CNT_W-1:0] word_t;

    typedef enum logic [1:0] {
        CS_DIV2  = 2'b00,
        CS_DIV8  = 2'b01,
        CS_DIV32 = 2'b10,
        CS_EXT   = 2'b11
    } clk_sel_e;

    typedef enum logic [2:0] {
        RA_CNT  = 3'd0,
        RA_CMPA = 3'd1,
        RA_CMPB = 3'd2,
        RA_CTRL = 3'd3,
        RA_STAT = 3'd4
    } reg_addr_e;

    // control word, bit 0 upward: sel[1:0], clr_a, oe_a, oe_b, lvl_a, lvl_b
    typedef struct packed {
        logic     lvl_b;
        logic     lvl_a;
        logic     oe_b;
        logic     oe_a;
        logic     clr_a;
        clk_sel_e sel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int NFLAG  = 3;

    // log2 of the division ratio for the internal sources
    function automatic int unsigned div_shift(clk_sel_e s);
        case (s)
            CS_DIV2:  return 1;
            CS_DIV8:  return 3;
            default:  return 5;
        endcase
    endfunction

endpackage

// File: rtl/frt_prescaler.sv
module frt_prescaler
    import frt_pkg::*;
#(
    parameter int W = PS_W
) (
    input  logic     clk,
    input  logic     rst,
    input  clk_sel_e sel,
    input  logic     ext_in,
    output logic     tick
);
    logic [W-1:0] div_q;
    logic [2:0]   sync_q;
    logic [W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            sync_q <= '0;
        end else begin
            div_q  <= div_q + 1'b1;
            sync_q <= {sync_q[1:0], ext_in};
        end
    end

    always_comb begin
        mask = W'((32'd1 << div_shift(sel)) - 32'd1);
        if (sel == CS_EXT)
            tick = sync_q[1] & ~sync_q[2];
        else
            tick = &(div_q | ~mask);
    end
endmodule

// File: rtl/frt_cmp_chan.sv
module frt_cmp_chan
    import frt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  word_t cnt_nxt,
    input  word_t ref_val,
    input  logic  oe,
    input  logic  lvl,
    output logic  match,
    output logic  pin
);
    assign match = step && (cnt_nxt == ref_val);

    always_ff @(posedge clk) begin
        if (rst)
            pin <= 1'b0;
        else if (match && oe)
            pin <= lvl;
    end
endmodule

// File: rtl/frt_flag.sv
module frt_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic rd_stat,
    input  logic wr_stat,
    input  logic wbit,
    output logic flag
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (set)
                flag <= 1'b1;
            else if (wr_stat && !wbit && armed)
                flag <= 1'b0;

            if (wr_stat)
                armed <= 1'b0;
            else if (rd_stat && flag)
                armed <= 1'b1;
        end
    end
endmodule

// File: rtl/frt_timer.sv
module frt_timer
    import frt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [1:0]  bus_be,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        ext_cnt_en,
    output logic        cmp_out_a,
    output logic        cmp_out_b
);
    localparam int NCH = 2;

    ctrl_t            ctrl_q;
    word_t            cnt_q;
    word_t            cnt_nxt;
    word_t            ocr_q [NCH];
    logic [NCH-1:0]   match_v;
    logic [NCH-1:0]   pin_v;
    logic [NFLAG-1:0] flag_v;
    logic [NFLAG-1:0] set_v;
    logic             tick;
    logic             step;
    logic             full_wr;
    logic             cnt_wr;
    logic             ovf_set;
    logic             rd_stat;
    logic             wr_stat;

    assign full_wr = bus_wr && (bus_be == 2'b11);
    assign cnt_wr  = full_wr && (bus_addr == RA_CNT);
    assign step    = tick && !cnt_wr;
    assign cnt_nxt = (ctrl_q.clr_a && (cnt_q == ocr_q[0])) ? '0 : cnt_q + 1'b1;
    assign ovf_set = step && (cnt_q == '1);
    assign rd_stat = bus_rd && (bus_addr == RA_STAT);
    assign wr_stat = bus_wr && bus_be[0] && (bus_addr == RA_STAT);

    frt_prescaler u_presc (
        .clk    (clk),
        .rst    (rst),
        .sel    (ctrl_q.sel),
        .ext_in (ext_cnt_en),
        .tick   (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (cnt_wr)
                cnt_q <= bus_wdata;
            else if (step)
                cnt_q <= cnt_nxt;
            if (bus_wr && bus_be[0] && (bus_addr == RA_CTRL))
                ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic oe_i;
        logic lvl_i;
        assign oe_i  = (i == 0) ? ctrl_q.oe_a  : ctrl_q.oe_b;
        assign lvl_i = (i == 0) ? ctrl_q.lvl_a : ctrl_q.lvl_b;

        always_ff @(posedge clk) begin
            if (rst)
                ocr_q[i] <= '1;
            else if (full_wr && (bus_addr == 3'(i + 1)))
                ocr_q[i] <= bus_wdata;
        end

        frt_cmp_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .step    (step),
            .cnt_nxt (cnt_nxt),
            .ref_val (ocr_q[i]),
            .oe      (oe_i),
            .lvl     (lvl_i),
            .match   (match_v[i]),
            .pin     (pin_v[i])
        );
    end

    assign set_v = {match_v, ovf_set};

    for (genvar f = 0; f < NFLAG; f++) begin : g_flag
        frt_flag u_flag (
            .clk     (clk),
            .rst     (rst),
            .set     (set_v[f]),
            .rd_stat (rd_stat),
            .wr_stat (wr_stat),
            .wbit    (bus_wdata[f]),
            .flag    (flag_v[f])
        );
    end

    always_comb begin
        case (bus_addr)
            RA_CNT:  bus_rdata = cnt_q;
            RA_CMPA: bus_rdata = ocr_q[0];
            RA_CMPB: bus_rdata = ocr_q[1];
            RA_CTRL: bus_rdata = 16'(ctrl_q);
            RA_STAT: bus_rdata = 16'(flag_v);
            default: bus_rdata = '0;
        endcase
    end

    assign cmp_out_a = pin_v[0];
    assign cmp_out_b = pin_v[1];
endmodule

// File: rtl/frt_timer_chk.sv
module frt_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        cnt_wr,
    input logic [15:0] bus_wdata,
    input logic        bus_wr,
    input logic [2:0]  bus_addr,
    input logic [1:0]  bus_be,
    input logic [15:0] cnt,
    input logic [15:0] ocra,
    input logic        clr_a,
    input logic        oe_a,
    input logic        match_a,
    input logic        flag_a,
    input logic        ovf,
    input logic        pin_a
);
    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && !(clr_a && cnt == ocra)) |=> cnt == 16'($past(cnt) + 16'd1));

    p_wrap_sets_ovf_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && cnt == 16'hFFFF) |=> ovf);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        match_a |=> flag_a);

    p_pin_rise_needs_match_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(pin_a) |-> $past(match_a && oe_a));

    p_byte_write_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd0 && bus_be != 2'b11 && !tick) |=> $stable(cnt));

    p_cpu_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> cnt == $past(bus_wdata));

    p_clear_on_match_r11: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && clr_a && cnt == ocra) |=> cnt == 16'h0000);
endmodule

bind frt_timer frt_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cnt_wr    (cnt_wr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .cnt       (cnt_q),
    .ocra      (ocr_q[0]),
    .clr_a     (ctrl_q.clr_a),
    .oe_a      (ctrl_q.oe_a),
    .match_a   (match_v[0]),
    .flag_a    (flag_v[1]),
    .ovf       (flag_v[0]),
    .pin_a     (cmp_out_a)
);

// File: tb/frt_timer_bench.sv
module frt_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [1:0]  bus_be = 2'b11;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_cnt_en = 1'b0;
    logic        cmp_out_a;
    logic        cmp_out_b;

    typedef struct {
        logic [15:0] val;
        string       req;
    } exp_t;

    exp_t   sb_q[$];
    int     n_checks = 0;
    int     n_fail = 0;
    bit     raw_rd = 1'b0;
    bit     done = 1'b0;
    logic [15:0] v1;

    always #4 clk = ~clk;

    frt_timer u_frt_timer (
        .clk        (clk),
        .rst        (rst),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_be     (bus_be),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ext_cnt_en (ext_cnt_en),
        .cmp_out_a  (cmp_out_a),
        .cmp_out_b  (cmp_out_b)
    );

    // monitor: compares each scoreboarded read in its own cycle
    always @(negedge clk) begin
        if (bus_rd && !rst && !raw_rd) begin
            exp_t e;
            n_checks++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard empty: actual %h expected none", bus_rdata);
            end else begin
                e = sb_q.pop_front();
                if (bus_rdata !== e.val) begin
                    n_fail++;
                    $display("FAIL %s: addr %0d actual %h expected %h", e.req, bus_addr, bus_rdata, e.val);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_be = 2'b11;
    endtask

    task automatic rd_exp(input logic [2:0] a, input logic [15:0] e, input string req);
        sb_q.push_back('{val: e, req: req});
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic rd_val(input logic [2:0] a, output logic [15:0] v);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1; raw_rd = 1'b1;
        @(negedge clk);
        v = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0; raw_rd = 1'b0;
    endtask

    // counter write followed by a read in the very next cycle
    task automatic wr_then_rd(input logic [15:0] d, input string req);
        sb_q.push_back('{val: d, req: req});
        @(posedge clk); #1;
        bus_addr = 3'd0; bus_wdata = d; bus_be = 2'b11; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic pulse();
        @(posedge clk); #1;
        ext_cnt_en = 1'b1;
        repeat (3) @(posedge clk);
        #1 ext_cnt_en = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic chk_pin(input logic act, input logic e, input string req);
        @(negedge clk);
        n_checks++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: pin actual %b expected %b", req, act, e);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset value, read in the first cycle out of reset
        sb_q.push_back('{val: 16'h0000, req: "R1"});
        rst = 1'b0; bus_addr = 3'd0; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        rd_exp(3'd1, 16'hFFFF, "R5");
        rd_exp(3'd2, 16'hFFFF, "R5");
        rd_exp(3'd4, 16'h0000, "R4");
        chk_pin(cmp_out_a, 1'b0, "R7");
        chk_pin(cmp_out_b, 1'b0, "R7");

        wr(3'd3, 16'h0003);               // external source, line idle
        wr(3'd0, 16'h1234);
        rd_exp(3'd0, 16'h1234, "R1");
        wr(3'd0, 16'hABCD, 2'b01);
        rd_exp(3'd0, 16'h1234, "R8");
        wr(3'd1, 16'h0005, 2'b10);
        rd_exp(3'd1, 16'hFFFF, "R8");

        repeat (3) pulse();
        rd_exp(3'd0, 16'h1237, "R3");
        rd_exp(3'd4, 16'h0000, "R5");

        wr(3'd0, 16'hFFFE);
        repeat (2) pulse();
        rd_exp(3'd0, 16'h0000, "R4");
        rd_exp(3'd4, 16'h0007, "R4");
        chk_pin(cmp_out_a, 1'b0, "R6");
        wr(3'd4, 16'h0000);
        rd_exp(3'd4, 16'h0000, "R9");

        wr(3'd0, 16'hFFFF);
        pulse();
        wr(3'd4, 16'h0000);               // no read before: must stay set
        rd_exp(3'd4, 16'h0001, "R9");
        wr(3'd4, 16'h0000);
        rd_exp(3'd4, 16'h0000, "R9");

        // channel B output enabled, level 1
        wr(3'd2, 16'h0010);
        wr(3'd3, 16'h0053);
        wr(3'd0, 16'h000E);
        pulse();
        chk_pin(cmp_out_b, 1'b0, "R7");
        pulse();
        chk_pin(cmp_out_b, 1'b1, "R6");
        rd_exp(3'd4, 16'h0004, "R5");
        wr(3'd4, 16'h0000);
        wr(3'd0, 16'h0010);
        rd_exp(3'd4, 16'h0000, "R5");

        // clear-on-match A with output A enabled at level 1
        wr(3'd1, 16'h0005);
        wr(3'd3, 16'h007F);
        wr(3'd0, 16'h0003);
        repeat (2) pulse();
        chk_pin(cmp_out_a, 1'b1, "R6");
        pulse();
        rd_exp(3'd0, 16'h0000, "R11");
        rd_exp(3'd4, 16'h0002, "R5");
        wr(3'd3, 16'h005F);
        wr(3'd0, 16'h0004);
        pulse();
        chk_pin(cmp_out_a, 1'b0, "R6");
        wr(3'd3, 16'h0077);               // output A disabled, level 1
        wr(3'd0, 16'h0004);
        pulse();
        chk_pin(cmp_out_a, 1'b0, "R6");

        // write priority over a coinciding count step, divide by 2
        wr(3'd3, 16'h0000);
        for (int ph = 0; ph < 2; ph++) begin
            repeat (ph) @(posedge clk);
            wr_then_rd(16'h0100, "R10");
        end

        // prescaler ratios: read spacing of N cycles gives N/ratio steps
        rd_val(3'd0, v1);
        repeat (62) @(posedge clk);
        rd_exp(3'd0, 16'(v1 + 16'd32), "R2");
        wr(3'd3, 16'h0001);
        rd_val(3'd0, v1);
        repeat (254) @(posedge clk);
        rd_exp(3'd0, 16'(v1 + 16'd32), "R2");
        wr(3'd3, 16'h0002);
        rd_val(3'd0, v1);
        repeat (1022) @(posedge clk);
        rd_exp(3'd0, 16'(v1 + 16'd32), "R2");

        repeat (2) @(posedge clk);
        if (sb_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule